// File: doc/BRIEF.md
# SPI Event Interrupt Latch

This block sits beside an SPI shift engine and turns its level status flags into interrupt causes. Thirteen status levels (transfer progress, FIFO fill state and FIFO error flags) are sampled into a register every clock. A cause bit is latched only when its sampled level goes from 0 to 1. A level that stays high, or one that falls, latches nothing.

Software reaches the block through a small register port with a two-bit word address. One word shows the live sampled levels. One holds the latched causes, which are cleared by writing ones. One holds the enable mask. A single interrupt line is raised while any latched cause has its mask bit set. Because only rising edges latch, a status that is already high when software unmasks it does not raise the line. Software must read the live levels to see that condition.

Top module: `spi_evt_irq`

## Requirements
- R1: The status-level word (address 0) returns the sampled levels. The bit positions are: 0 shift done, 1 engine idle-ready, 2 receive FIFO has data at threshold, 3 transmit FIFO has room at threshold, 4 receive FIFO empty, 5 receive FIFO full, 6 transmit FIFO empty, 7 transmit FIFO full, 8 receive underflow, 9 receive overflow, 10 transmit underflow, 11 transmit overflow, 12 header address missing. A read strobed in one cycle returns data on `rd_data` after the next clock edge. The word reflects a change of `status_i` one edge after that change is sampled.
- R2: A cause bit (address 1) sets only when its sampled level changes from 0 to 1. A level held high does not set the bit again once it has been cleared.
- R3: Writing to address 1 clears each cause bit whose write-data bit is 1 and leaves the others unchanged. Writing all ones clears every cause.
- R4: `irq_o` is a register that goes high one edge after some cause bit and its mask bit (address 2) are both set. It falls one edge after no such pair remains.
- R5: After reset the cause word, the mask word and `irq_o` are all zero.
- R6: A status level that is already high when its mask bit is set does not raise `irq_o`.
- R7: When a rising edge and a clearing write hit the same cause bit in the same cycle, the bit stays set.
- R8: Data bits at or above position 13 read as zero at every address. Address 3 reads as all zeros.
- R9: A write to address 0 has no effect on any readable word.
- R10: A falling status level does not set its cause bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| status_i | input | 13 | Live status levels from the SPI engine |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Word address: 0 levels, 1 causes, 2 mask, 3 unused |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data, valid one edge after `rd_en` |
| irq_o | output | 1 | Interrupt request |

## Verification
A change on `status_i` driven between edges is sampled at the first edge. The cause it produces is latched at the second edge, and `irq_o` follows at the third. A read launched after the second edge returns that cause. The bench drives at falling edges and samples at falling edges. It checks `irq_o` low after two edges and high after the third, so a design that is one register short or one register long fails. A clear written in one cycle takes effect at that edge, and the line drops one edge later. The same-cycle set/clear case is driven so that the write lands exactly on the edge where the rise is first seen.

// File: rtl/spi_evt_pkg.sv
package spi_evt_pkg;
  typedef enum logic [1:0] {
    SEL_LEVEL = 2'd0,
    SEL_CAUSE = 2'd1,
    SEL_MASK  = 2'd2,
    SEL_NONE  = 2'd3
  } evt_sel_e;
endpackage

// File: rtl/spi_evt_sample.sv
module spi_evt_sample #(
  parameter int NSRC = 13
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] status_i,
  output logic [NSRC-1:0] level_q,
  output logic [NSRC-1:0] rise
);
  logic [NSRC-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      level_q <= '0;
      prev_q  <= '0;
    end else begin
      level_q <= status_i;
      prev_q  <= level_q;
    end
  end

  assign rise = level_q & ~prev_q;
endmodule

// File: rtl/spi_evt_cause.sv
module spi_evt_cause #(
  parameter int NSRC = 13
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] rise,
  input  logic            clr_we,
  input  logic [NSRC-1:0] clr_bits,
  input  logic            mask_we,
  input  logic [NSRC-1:0] mask_bits,
  output logic [NSRC-1:0] cause_q,
  output logic [NSRC-1:0] mask_q,
  output logic            irq_q
);
  for (genvar i = 0; i < NSRC; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) begin
        cause_q[i] <= 1'b0;
        mask_q[i]  <= 1'b0;
      end else begin
        // a rise takes priority over a clear in the same cycle
        if (rise[i])
          cause_q[i] <= 1'b1;
        else if (clr_we && clr_bits[i])
          cause_q[i] <= 1'b0;
        if (mask_we)
          mask_q[i] <= mask_bits[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(cause_q & mask_q);
  end
endmodule

// File: rtl/spi_evt_regs.sv
module spi_evt_regs
  import spi_evt_pkg::*;
#(
  parameter int NSRC = 13,
  parameter int DW   = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            rd_en,
  input  logic [1:0]      addr,
  input  logic [NSRC-1:0] level_q,
  input  logic [NSRC-1:0] cause_q,
  input  logic [NSRC-1:0] mask_q,
  output logic [DW-1:0]   rd_data
);
  localparam int PAD = DW - NSRC;
  logic [NSRC-1:0] pick;

  always_comb begin
    unique case (evt_sel_e'(addr))
      SEL_LEVEL: pick = level_q;
      SEL_CAUSE: pick = cause_q;
      SEL_MASK:  pick = mask_q;
      default:   pick = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= {{PAD{1'b0}}, pick};
  end
endmodule

// File: rtl/spi_evt_irq.sv
module spi_evt_irq
  import spi_evt_pkg::*;
#(
  parameter int NSRC = 13,
  parameter int DW   = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] status_i,
  input  logic            wr_en,
  input  logic            rd_en,
  input  logic [1:0]      addr,
  input  logic [DW-1:0]   wr_data,
  output logic [DW-1:0]   rd_data,
  output logic            irq_o
);
  logic [NSRC-1:0] level_q, rise, cause_q, mask_q;
  logic            clr_we, mask_we;

  assign clr_we  = wr_en && (evt_sel_e'(addr) == SEL_CAUSE);
  assign mask_we = wr_en && (evt_sel_e'(addr) == SEL_MASK);

  spi_evt_sample #(.NSRC(NSRC)) u_sample (
    .clk(clk), .rst(rst), .status_i(status_i),
    .level_q(level_q), .rise(rise)
  );

  spi_evt_cause #(.NSRC(NSRC)) u_cause (
    .clk(clk), .rst(rst), .rise(rise),
    .clr_we(clr_we), .clr_bits(wr_data[NSRC-1:0]),
    .mask_we(mask_we), .mask_bits(wr_data[NSRC-1:0]),
    .cause_q(cause_q), .mask_q(mask_q), .irq_q(irq_o)
  );

  spi_evt_regs #(.NSRC(NSRC), .DW(DW)) u_regs (
    .clk(clk), .rst(rst), .rd_en(rd_en), .addr(addr),
    .level_q(level_q), .cause_q(cause_q), .mask_q(mask_q),
    .rd_data(rd_data)
  );
endmodule

// File: rtl/spi_evt_irq_chk.sv
module spi_evt_irq_chk #(
  parameter int NSRC = 13,
  parameter int DW   = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            wr_en,
  input logic [1:0]      addr,
  input logic [DW-1:0]   wr_data,
  input logic [DW-1:0]   rd_data,
  input logic            irq_o,
  input logic [NSRC-1:0] level,
  input logic [NSRC-1:0] cause,
  input logic [NSRC-1:0] mask
);
  logic [NSRC-1:0] level_d;
  logic [NSRC-1:0] up;

  always_ff @(posedge clk) begin
    if (rst) level_d <= '0;
    else     level_d <= level;
  end
  assign up = level & ~level_d;

  // R2: a newly set cause bit always comes from a rise of its level
  p_set_only_on_rise_r2: assert property (@(posedge clk) disable iff (rst)
    ((cause & ~$past(cause) & ~$past(up)) == '0));

  // R3: a cause bit is only cleared by a write of one to the cause word
  p_clear_needs_write_r3: assert property (@(posedge clk) disable iff (rst)
    (($past(cause) & ~cause &
      ~(($past(wr_en) && $past(addr) == 2'd1) ? $past(wr_data[NSRC-1:0]) : '0)) == '0));

  // R7: a rise is never lost, even against a clear
  p_set_wins_r7: assert property (@(posedge clk) disable iff (rst)
    (($past(up) & ~cause) == '0));

  // R4: no enabled cause means the line is low one edge later
  p_irq_low_r4: assert property (@(posedge clk) disable iff (rst)
    ((cause & mask) == '0) |=> !irq_o);

  // R4: an enabled cause means the line is high one edge later
  p_irq_high_r4: assert property (@(posedge clk) disable iff (rst)
    ((cause & mask) != '0) |=> irq_o);

  // R8: upper read bits are always zero
  p_upper_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (rd_data[DW-1:NSRC] == '0));

  // R9: the mask changes only on a write to its own word
  p_mask_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && addr == 2'd2) |=> $stable(mask));
endmodule

bind spi_evt_irq spi_evt_irq_chk #(.NSRC(NSRC), .DW(DW)) chk_i (
  .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
  .rd_data(rd_data), .irq_o(irq_o), .level(level_q), .cause(cause_q),
  .mask(mask_q)
);

// File: tb/spi_evt_irq_tb_top.sv
module spi_evt_irq_tb_top;
  localparam int NSRC = 13;
  localparam int DW   = 32;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [NSRC-1:0] status_i = '0;
  logic            wr_en = 1'b0;
  logic            rd_en = 1'b0;
  logic [1:0]      addr = '0;
  logic [DW-1:0]   wr_data = '0;
  logic [DW-1:0]   rd_data;
  logic            irq_o;

  int n_chk = 0;
  int n_err = 0;

  always #4 clk = ~clk;

  spi_evt_irq #(.NSRC(NSRC), .DW(DW)) dut_i (
    .clk(clk), .rst(rst), .status_i(status_i), .wr_en(wr_en),
    .rd_en(rd_en), .addr(addr), .wr_data(wr_data), .rd_data(rd_data),
    .irq_o(irq_o)
  );

  task automatic check(input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [DW-1:0] d);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [DW-1:0] v;
    rd(2'd1, v); check("R5 cause after reset", v, '0);
    rd(2'd2, v); check("R5 mask after reset", v, '0);
    check("R5 irq after reset", {31'd0, irq_o}, '0);
  endtask

  task automatic t_levels();
    logic [DW-1:0] v;
    status_i = 13'h1A5C;
    @(negedge clk);
    rd(2'd0, v); check("R1 live levels", v, 32'h1A5C);
    status_i = 13'h05A3;
    @(negedge clk);
    rd(2'd0, v); check("R1 live levels second pattern", v, 32'h05A3);
    settle();
    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd1, v); check("R3 all-ones clears every cause", v, '0);
    status_i = '0; settle();
    wr(2'd1, 32'hFFFF_FFFF);
  endtask

  task automatic t_edge();
    logic [DW-1:0] v;
    status_i = 13'h0010; settle();
    rd(2'd1, v); check("R2 rise latches only bit 4", v, 32'h0010);
    wr(2'd1, 32'h0000_0000);
    rd(2'd1, v); check("R3 zero write keeps cause", v, 32'h0010);
    wr(2'd1, 32'h0000_0010);
    settle();
    rd(2'd1, v); check("R2 held level does not relatch", v, '0);
    status_i = '0; settle();
    rd(2'd1, v); check("R10 fall sets nothing", v, '0);
  endtask

  task automatic t_irq();
    logic [DW-1:0] v;
    wr(2'd2, 32'h0000_0001);
    status_i = 13'h0002; settle();
    check("R4 masked-off cause keeps irq low", {31'd0, irq_o}, '0);
    status_i = 13'h0003;
    @(negedge clk); check("R4 irq low after one edge", {31'd0, irq_o}, '0);
    @(negedge clk); check("R4 irq low after two edges", {31'd0, irq_o}, '0);
    @(negedge clk); check("R4 irq high after three edges", {31'd0, irq_o}, 32'd1);
    wr(2'd1, 32'h0000_0001);
    check("R4 irq still high at clear edge", {31'd0, irq_o}, 32'd1);
    @(negedge clk); check("R4 irq low one edge after clear", {31'd0, irq_o}, '0);
    rd(2'd1, v); check("R3 only bit 0 cleared", v, 32'h0002);
    wr(2'd1, 32'hFFFF_FFFF);
  endtask

  task automatic t_already_high();
    logic [DW-1:0] v;
    wr(2'd2, '0);
    status_i = 13'h0008; settle();
    wr(2'd1, 32'h0000_0008);
    wr(2'd2, 32'h0000_0008);
    settle();
    check("R6 unmask of high level keeps irq low", {31'd0, irq_o}, '0);
    rd(2'd0, v); check("R6 level still visible", v, 32'h0008);
    status_i = '0; settle();
    wr(2'd2, '0);
    wr(2'd1, 32'hFFFF_FFFF);
  endtask

  task automatic t_collide();
    logic [DW-1:0] v;
    status_i = 13'h0003; settle();
    status_i = '0; settle();
    status_i = 13'h0001;
    @(negedge clk);
    wr(2'd1, 32'h0000_0003);
    rd(2'd1, v); check("R7 set wins over same-cycle clear", v, 32'h0001);
    status_i = '0; settle();
    wr(2'd1, 32'hFFFF_FFFF);
  endtask

  task automatic t_space();
    logic [DW-1:0] v;
    wr(2'd2, 32'hFFFF_FFFF);
    rd(2'd2, v); check("R8 mask upper bits zero", v, 32'h0000_1FFF);
    rd(2'd3, v); check("R8 unused word reads zero", v, '0);
    wr(2'd2, '0);
    status_i = 13'h0444; settle();
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, v); check("R9 level word ignores write", v, 32'h0444);
    rd(2'd2, v); check("R9 mask untouched", v, '0);
    rd(2'd1, v); check("R9 cause untouched", v, 32'h0444);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_levels();
    t_edge();
    t_irq();
    t_already_high();
    t_collide();
    t_space();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule